// File: doc/BRIEF.md
# Restoring Array Divider

This block divides one unsigned operand by another in a single combinational pass and delivers the integer quotient. The array is fully unrolled: it has one row per quotient bit, and each row is a chain of one-bit subtractors linked by their borrows. Every row tries to subtract the divisor from the current partial remainder.

If a row ends in a borrow, the trial failed. That row's quotient bit is then zero, and a bank of two-way selectors passes the unchanged partial remainder to the next row. If the row ends with no borrow, its quotient bit is one and the difference moves on. Before entering the next row, the surviving remainder is shifted up one place and the next lower dividend bit is brought in beneath it. The final row only has to decide its borrow, so it is built as a borrow-only comparator.

The block has no clock and no state. It is meant to sit between register stages of a datapath that can absorb its depth, which grows with the square of the operand width.

Top module: `restoring_array_div`

## Requirements
- R1: For any nonzero divisor, quotient equals the integer part of dividend / divisor, with both operands unsigned and WIDTH bits wide (exhaustive at WIDTH = 4).
- R2: With divisor = 1, quotient equals the dividend.
- R3: When the dividend is smaller than a nonzero divisor, quotient is zero.
- R4: When dividend equals a nonzero divisor, quotient is one.
- R5: When the divisor is a power of two 2^k, quotient equals the dividend shifted right by k places.
- R6: With divisor = 0, no row ever borrows, so every quotient bit is one (all ones at the output). This case is not flagged.
- R7: At WIDTH = 8 the quotient is correct for the extreme operands (largest dividend, largest divisor, a divisor with only the top bit set) and for random operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | WIDTH | Unsigned number to be divided |
| divisor | input | WIDTH | Unsigned number to divide by |
| quotient | output | WIDTH | Unsigned integer quotient, bit WIDTH-1 produced by the first row |

## Verification
Whenever the operands are known, the bound checker tests the defining bounds of a quotient: the quotient times the divisor does not exceed the dividend, and the amount left over is smaller than the divisor. It also checks the fixed results for a unit divisor, a power-of-two divisor, equal operands, a small dividend and a zero divisor. The assertions cannot show that every operand pair was actually visited, or that a second width elaborates and divides correctly. Only the bench's exhaustive 4-bit sweep and its 8-bit corner and random pairs show those.

// File: rtl/rad_pkg.sv
package rad_pkg;

  // Difference bit of a one-bit subtract x - y - bin
  function automatic logic sub_diff(input logic x, input logic y, input logic bin);
    return x ^ y ^ bin;
  endfunction

  // Borrow out of a one-bit subtract x - y - bin
  function automatic logic sub_borrow(input logic x, input logic y, input logic bin);
    return (~x & y) | (~(x ^ y) & bin);
  endfunction

endpackage

// File: rtl/rad_fsub_cell.sv
module rad_fsub_cell
  import rad_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic bin_i,
  output logic d_o,
  output logic bout_o
);

  assign d_o    = sub_diff(x_i, y_i, bin_i);
  assign bout_o = sub_borrow(x_i, y_i, bin_i);

endmodule

// File: rtl/rad_borrow_cell.sv
module rad_borrow_cell
  import rad_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic bin_i,
  output logic bout_o
);

  assign bout_o = sub_borrow(x_i, y_i, bin_i);

endmodule

// File: rtl/rad_sub_row.sv
// One trial-subtract row. The top difference bit is never needed
// (the surviving remainder always fits in WIDTH-1 bits), so the top
// position is a borrow-only cell.
module rad_sub_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-2:0] diff_o,
  output logic             borrow_o
);

  localparam int LOW_BITS = WIDTH - 1;

  logic [WIDTH-1:0] chain;

  for (genvar j = 0; j < LOW_BITS; j++) begin : g_cell
    logic bin;
    if (j == 0) begin : g_lsb
      assign bin = 1'b0;
    end else begin : g_mid
      assign bin = chain[j-1];
    end
    rad_fsub_cell u_cell (
      .x_i    (rem_i[j]),
      .y_i    (dvs_i[j]),
      .bin_i  (bin),
      .d_o    (diff_o[j]),
      .bout_o (chain[j])
    );
  end

  rad_borrow_cell u_top (
    .x_i    (rem_i[LOW_BITS]),
    .y_i    (dvs_i[LOW_BITS]),
    .bin_i  (chain[LOW_BITS-1]),
    .bout_o (chain[LOW_BITS])
  );

  assign borrow_o = chain[LOW_BITS];

endmodule

// File: rtl/rad_cmp_row.sv
// Final row: only its borrow (the last quotient bit) is consumed.
module rad_cmp_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic             borrow_o
);

  logic [WIDTH-1:0] chain;

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    logic bin;
    if (j == 0) begin : g_lsb
      assign bin = 1'b0;
    end else begin : g_up
      assign bin = chain[j-1];
    end
    rad_borrow_cell u_cell (
      .x_i    (rem_i[j]),
      .y_i    (dvs_i[j]),
      .bin_i  (bin),
      .bout_o (chain[j])
    );
  end

  assign borrow_o = chain[WIDTH-1];

endmodule

// File: rtl/rad_restore_mux.sv
module rad_restore_mux #(
  parameter int BITS = 7
) (
  input  logic            restore_i,
  input  logic [BITS-1:0] prev_i,
  input  logic [BITS-1:0] diff_i,
  output logic [BITS-1:0] rem_o
);

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    assign rem_o[k] = restore_i ? prev_i[k] : diff_i[k];
  end

endmodule

// File: rtl/restoring_array_div.sv
// Unrolled restoring divider: WIDTH rows, quotient MSB from row 0.
// WIDTH must be at least 2.
module restoring_array_div #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient
);

  localparam int ROWS     = WIDTH;
  localparam int REM_BITS = WIDTH - 1;

  logic [ROWS-1:0][WIDTH-1:0]    row_in;
  logic [ROWS-1:0][REM_BITS-1:0] row_rem;
  logic [ROWS-1:0][REM_BITS-1:0] row_diff;
  logic [ROWS-1:0]               row_borrow;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // Partial remainder entering this row
    if (r == 0) begin : g_first
      assign row_in[r] = {{REM_BITS{1'b0}}, dividend[WIDTH-1]};
    end else begin : g_next
      assign row_in[r] = {row_rem[r-1], dividend[WIDTH-1-r]};
    end

    if (r < ROWS - 1) begin : g_trial
      rad_sub_row #(.WIDTH(WIDTH)) u_sub (
        .rem_i    (row_in[r]),
        .dvs_i    (divisor),
        .diff_o   (row_diff[r]),
        .borrow_o (row_borrow[r])
      );
      rad_restore_mux #(.BITS(REM_BITS)) u_mux (
        .restore_i (row_borrow[r]),
        .prev_i    (row_in[r][REM_BITS-1:0]),
        .diff_i    (row_diff[r]),
        .rem_o     (row_rem[r])
      );
    end else begin : g_last
      rad_cmp_row #(.WIDTH(WIDTH)) u_cmp (
        .rem_i    (row_in[r]),
        .dvs_i    (divisor),
        .borrow_o (row_borrow[r])
      );
      assign row_diff[r] = '0;
      assign row_rem[r]  = '0;
    end

    assign quotient[WIDTH-1-r] = ~row_borrow[r];
  end

endmodule

// File: rtl/restoring_array_div_chk.sv
module restoring_array_div_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic [WIDTH-1:0] quotient
);

  logic [2*WIDTH-1:0] prod;
  logic [2*WIDTH-1:0] num_ext;
  logic [2*WIDTH-1:0] dvs_ext;
  int unsigned        shamt;

  always_comb begin
    num_ext = {{WIDTH{1'b0}}, dividend};
    dvs_ext = {{WIDTH{1'b0}}, divisor};
    prod    = {{WIDTH{1'b0}}, quotient} * dvs_ext;
    shamt   = 0;
    for (int k = 0; k < WIDTH; k++) begin
      if (divisor[k]) shamt = k;
    end
    if (!$isunknown({dividend, divisor, quotient})) begin
      if (divisor != '0) begin
        AST_QUOT_BOUND: assert (prod <= num_ext && (num_ext - prod) < dvs_ext)
          else $error("quotient out of bounds"); // R1
      end
      if (divisor == WIDTH'(1)) begin
        AST_UNIT_DIVISOR: assert (quotient == dividend)
          else $error("unit divisor"); // R2
      end
      if (divisor != '0 && dividend < divisor) begin
        AST_SMALL_DIVIDEND: assert (quotient == '0)
          else $error("small dividend"); // R3
      end
      if (divisor != '0 && dividend == divisor) begin
        AST_EQUAL_OPERANDS: assert (quotient == WIDTH'(1))
          else $error("equal operands"); // R4
      end
      if ($countones(divisor) == 1) begin
        AST_POW2_SHIFT: assert (quotient == (dividend >> shamt))
          else $error("power of two divisor"); // R5
      end
      if (divisor == '0) begin
        AST_ZERO_DIVISOR: assert (quotient == '1)
          else $error("zero divisor"); // R6
      end
    end
  end

endmodule

bind restoring_array_div restoring_array_div_chk #(.WIDTH(WIDTH)) u_chk (
  .dividend (dividend),
  .divisor  (divisor),
  .quotient (quotient)
);

// File: tb/restoring_array_div_tb.sv
`timescale 1ns/1ps
module restoring_array_div_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic       rst_n;
  logic [3:0] a4, b4;
  logic [3:0] q4;
  logic [7:0] a8, b8;
  logic [7:0] q8;

  restoring_array_div #(.WIDTH(4)) u_dut (
    .dividend (a4), .divisor (b4), .quotient (q4)
  );
  restoring_array_div #(.WIDTH(8)) u_dut_w8 (
    .dividend (a8), .divisor (b8), .quotient (q8)
  );

  typedef struct {
    bit         wide;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [7:0] ref_div(bit wide, logic [7:0] a, logic [7:0] b);
    if (b == 0) return wide ? 8'hFF : 8'h0F;
    return a / b;
  endfunction

  function automatic string pick_tag(bit wide, logic [7:0] a, logic [7:0] b);
    if (b == 0) return "R6";
    if (a == b) return "R4";
    if (a < b) return "R3";
    if (b == 1) return "R2";
    if ($countones(b) == 1) return "R5";
    if (wide) return "R7";
    return "R1";
  endfunction

  task automatic drive(bit wide, logic [7:0] a, logic [7:0] b);
    item_t it;
    @(posedge clk);
    #1;
    if (wide) begin
      a8 = a; b8 = b;
    end else begin
      a4 = a[3:0]; b4 = b[3:0];
    end
    it.wide = wide;
    it.a    = a;
    it.b    = b;
    it.exp  = ref_div(wide, a, b);
    it.tag  = pick_tag(wide, a, b);
    sbq.push_back(it);
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sbq.pop_front();
      act = it.wide ? q8 : {4'b0, q4};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s w=%0d a=%0d b=%0d actual=%0d expected=%0d",
                 it.tag, it.wide ? 8 : 4, it.a, it.b, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    a4 = 4'd0; b4 = 4'd1; a8 = 8'd0; b8 = 8'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time output with 0 / 1 operands (R3)
    n_cmp++;
    if (q4 !== 4'd0 || q8 !== 8'd0) begin
      n_bad++;
      $display("FAIL R3 reset state actual=%0d/%0d expected=0/0", q4, q8);
    end
    rst_n = 1'b1;

    // R1..R6: exhaustive 4-bit sweep, zero divisor included
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive(1'b0, 8'(a), 8'(b));
      end
    end

    // R7: 8-bit extremes
    drive(1'b1, 8'd255, 8'd1);
    drive(1'b1, 8'd255, 8'd255);
    drive(1'b1, 8'd128, 8'd255);
    drive(1'b1, 8'd255, 8'd128);
    drive(1'b1, 8'd254, 8'd127);
    drive(1'b1, 8'd255, 8'd16);
    drive(1'b1, 8'd0,   8'd7);
    drive(1'b1, 8'd200, 8'd0);
    drive(1'b1, 8'd255, 8'd2);
    drive(1'b1, 8'd129, 8'd128);

    // R7: random 8-bit pairs with nonzero divisor
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (rb == 0) rb = 8'd1;
      drive(1'b1, ra, rb);
    end

    while (sbq.size() > 0) @(negedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule